// File: doc/BRIEF.md
# Indirect-Window GPIO Port Controller

This block drives one eight-pin general-purpose port and hides most of its configuration behind a two-step access window. Software first loads a sub-register index into an index register. It then reads or writes the selected configuration word through a single window register. Three sub-registers are implemented: pin direction, alternate-function enable and open-drain select. An output data register and a synchronized input sample register sit directly on the bus.

Each pin chooses its drive source. In normal mode, the output data bit sets the value and the direction bit sets the enable. When its alternate-function bit is set, an external function supplies the value and the enable. Open-drain select sits after that choice, so it also limits a pin driven by an alternate function. The pad is driven only while the selected value is low.

The bus is a plain synchronous interface. A write is one cycle with `bus_wr` high. A read is combinational from `bus_sel`.

Top module: `gpio_iport`

## Requirements
- R1: `bus_sel`=0 selects the index register. A write loads it, it resets to 00h, and a read returns the last value written.
- R2: `bus_sel`=1 is the window onto the sub-register named by the index. Index 01h is the direction register: it resets to FFh, and a 1 makes the pin an input.
- R3: Window index 02h is the alternate-function enable register. It resets to the parameter `AF_RESET` (default 00h), and all bits are readable and writable.
- R4: Window index 03h is the open-drain select register. It resets to 00h, so every pin starts in push-pull mode.
- R5: Any other window index reads as 00h. A write through the window at such an index changes no sub-register.
- R6: A pin whose alternate-function bit is 0 and whose open-drain bit is 0 drives `pad_out` from its output data bit. `pad_oe` is the inverse of its direction bit.
- R7: A pin whose alternate-function bit is 1 and whose open-drain bit is 0 copies `alt_out` to `pad_out` and `alt_oe` to `pad_oe`.
- R8: A pin whose open-drain bit is 1 asserts `pad_oe` only when its selected value is 0 and its selected source wants to drive. This holds in both modes.
- R9: `bus_sel`=2 is the output data register. It resets to 00h and reads back its value. A write reaches `pad_out` one clock after the write cycle.
- R10: `bus_sel`=3 reads the input sample. It equals `pad_in` as it was two clock edges earlier, in any pin mode, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 2 | Register select: 0 index, 1 window, 2 output data, 3 input sample |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current `bus_sel` |
| alt_out | input | 8 | Alternate-function output value per pin |
| alt_oe | input | 8 | Alternate-function drive enable per pin |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable, 1 drives |

## Verification
The window is the only path to the configuration. A wrong index or a misrouted window write leaves a sub-register holding a stale or foreign value. That error shows at the pads in the cycle after the write, and on a read-back of the window at once. A bad mode selection appears as `pad_out` or `pad_oe` following the wrong source, which is visible combinationally while the alternate inputs toggle. A fault in the synchronizer shows as the input sample arriving one edge early or late.

// File: rtl/gpio_iport_pkg.sv
package gpio_iport_pkg;

  typedef enum logic [1:0] {
    BUS_INDEX  = 2'd0,
    BUS_WINDOW = 2'd1,
    BUS_DATA   = 2'd2,
    BUS_INPUT  = 2'd3
  } bus_reg_e;

  // one-hot window decode: bit0 direction, bit1 alt-enable, bit2 open-drain
  typedef logic [2:0] win_hit_t;

  // selected value for one pin
  function automatic logic pin_value(input logic alt_en, input logic data_bit,
                                     input logic alt_val);
    return alt_en ? alt_val : data_bit;
  endfunction

  // selected drive enable for one pin, open-drain applied after the mode mux
  function automatic logic pin_drive(input logic alt_en, input logic dir_in,
                                     input logic alt_en_oe, input logic odrain,
                                     input logic value);
    logic want;
    want = alt_en ? alt_en_oe : ~dir_in;
    return odrain ? (want & ~value) : want;
  endfunction

endpackage

// File: rtl/gpio_subreg_bank.sv
module gpio_subreg_bank
  import gpio_iport_pkg::*;
#(
  parameter int          PINS     = 8,
  parameter logic [PINS-1:0] AF_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  bus_reg_e        wr_sel,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] index_q,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] alten_q,
  output logic [PINS-1:0] odrain_q,
  output logic [PINS-1:0] odata_q,
  output logic [PINS-1:0] win_rdata,
  output win_hit_t        win_hit
);

  localparam logic [PINS-1:0] IDX_DIR    = PINS'(1);
  localparam logic [PINS-1:0] IDX_ALTEN  = PINS'(2);
  localparam logic [PINS-1:0] IDX_ODRAIN = PINS'(3);

  logic win_wr;

  always_comb begin
    win_hit[0] = (index_q == IDX_DIR);
    win_hit[1] = (index_q == IDX_ALTEN);
    win_hit[2] = (index_q == IDX_ODRAIN);
  end

  assign win_wr = wr_en && (wr_sel == BUS_WINDOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      dir_q    <= '1;
      alten_q  <= AF_RESET;
      odrain_q <= '0;
      odata_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        BUS_INDEX: index_q <= wdata;
        BUS_DATA:  odata_q <= wdata;
        BUS_WINDOW: begin
          if (win_hit[0]) dir_q    <= wdata;
          if (win_hit[1]) alten_q  <= wdata;
          if (win_hit[2]) odrain_q <= wdata;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    win_rdata = '0;
    if (win_hit[0]) win_rdata = dir_q;
    if (win_hit[1]) win_rdata = alten_q;
    if (win_hit[2]) win_rdata = odrain_q;
  end

  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == BUS_INDEX |=> index_q == $past(wdata));

  a_r2_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));

  a_r5_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && win_hit == 3'b000 |=> $stable(dir_q) && $stable(alten_q) && $stable(odrain_q));

  a_r5_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit == 3'b000 |-> win_rdata == '0);

  a_r9_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == BUS_DATA |=> odata_q == $past(wdata));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_iport_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] alten_q,
  input  logic [PINS-1:0] odrain_q,
  input  logic [PINS-1:0] odata_q,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic val;
    assign val        = pin_value(alten_q[p], odata_q[p], alt_out[p]);
    assign pad_out[p] = val;
    assign pad_oe[p]  = pin_drive(alten_q[p], dir_q[p], alt_oe[p], odrain_q[p], val);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] sample
);

  logic [PINS-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= pad_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sample = chain[STAGES-1];

endmodule

// File: rtl/gpio_iport.sv
module gpio_iport
  import gpio_iport_pkg::*;
#(
  parameter int              PINS        = 8,
  parameter logic [PINS-1:0] AF_RESET    = '0,
  parameter int              SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [1:0]      bus_sel,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  bus_reg_e        sel;
  logic [PINS-1:0] index_q, dir_q, alten_q, odrain_q, odata_q, win_rdata, sample;
  win_hit_t        win_hit;

  assign sel = bus_reg_e'(bus_sel);

  gpio_subreg_bank #(.PINS(PINS), .AF_RESET(AF_RESET)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_sel(sel), .wdata(bus_wdata),
    .index_q(index_q), .dir_q(dir_q), .alten_q(alten_q), .odrain_q(odrain_q),
    .odata_q(odata_q), .win_rdata(win_rdata), .win_hit(win_hit)
  );

  gpio_pin_mux #(.PINS(PINS)) u_mux (
    .dir_q(dir_q), .alten_q(alten_q), .odrain_q(odrain_q), .odata_q(odata_q),
    .alt_out(alt_out), .alt_oe(alt_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .sample(sample)
  );

  always_comb begin
    case (sel)
      BUS_INDEX:  bus_rdata = index_q;
      BUS_WINDOW: bus_rdata = win_rdata;
      BUS_DATA:   bus_rdata = odata_q;
      default:    bus_rdata = sample;
    endcase
  end

  // pin-level checks
  for (genvar p = 0; p < PINS; p++) begin : g_chk
    a_r8_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      odrain_q[p] && pad_oe[p] |-> !pad_out[p]);
    a_r6_input_floats: assert property (@(posedge clk) disable iff (!rst_n)
      !alten_q[p] && dir_q[p] |-> !pad_oe[p]);
    a_r7_alt_follows: assert property (@(posedge clk) disable iff (!rst_n)
      alten_q[p] && !odrain_q[p] |-> pad_out[p] == alt_out[p] && pad_oe[p] == alt_oe[p]);
  end

  // input latency check, only for the two-stage default
  if (SYNC_STAGES == 2) begin : g_sync_chk
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
    a_r10_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst == 2'd2 |-> sample == $past(pad_in, 2));
  end

endmodule

// File: tb/sim_gpio_iport.sv
module sim_gpio_iport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] alt_out = '0, alt_oe = '0, pad_in = '0;
  logic [7:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the configuration
  logic [7:0] m_idx = 8'h00, m_dir = 8'hFF, m_af = 8'h00, m_od = 8'h00, m_data = 8'h00;

  gpio_iport u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_out(alt_out),
    .alt_oe(alt_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #10ns clk = ~clk;  // 50 MHz

  function automatic logic [7:0] exp_out(logic [7:0] af, logic [7:0] d, logic [7:0] ao);
    return (af & ao) | (~af & d);
  endfunction

  function automatic logic [7:0] exp_oe(logic [7:0] af, logic [7:0] dir, logic [7:0] aoe,
                                        logic [7:0] od, logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      logic src_drv;
      src_drv = af[i] ? aoe[i] : !dir[i];
      if (od[i]) r[i] = src_drv && (v[i] == 1'b0);
      else       r[i] = src_drv;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_win(logic [7:0] idx);
    case (idx)
      8'h01:   return m_dir;
      8'h02:   return m_af;
      8'h03:   return m_od;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (sel)
      2'd0: m_idx = d;
      2'd1: case (m_idx)
              8'h01: m_dir = d;
              8'h02: m_af  = d;
              8'h03: m_od  = d;
              default: ;
            endcase
      2'd2: m_data = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] d);
    bus_sel = sel;
    #1ns;
    d = bus_rdata;
  endtask

  task automatic check_pads(string req);
    #1ns;
    check({req, " pad_out"}, pad_out, exp_out(m_af, m_data, alt_out));
    check({req, " pad_oe"}, pad_oe,
          exp_oe(m_af, m_dir, alt_oe, m_od, exp_out(m_af, m_data, alt_out)));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #3000000ns;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] r, prev;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(2'd0, r); check("R1 index reset", r, 8'h00);
    rd(2'd1, r); check("R5 index 00 reads zero", r, 8'h00);
    rd(2'd2, r); check("R9 data reset", r, 8'h00);
    check_pads("R6 reset all inputs");
    wr(2'd0, 8'h01); rd(2'd1, r); check("R2 dir reset", r, 8'hFF);
    wr(2'd0, 8'h02); rd(2'd1, r); check("R3 alt-enable reset", r, 8'h00);
    wr(2'd0, 8'h03); rd(2'd1, r); check("R4 open-drain reset", r, 8'h00);
    wr(2'd0, 8'hA7); rd(2'd0, r); check("R1 index readback", r, 8'hA7);

    // R5: writes at unmapped indices leave sub-registers alone
    wr(2'd0, 8'h00); wr(2'd1, 8'h5A);
    wr(2'd0, 8'h04); wr(2'd1, 8'h3C);
    rd(2'd1, r); check("R5 index 04 reads zero", r, 8'h00);
    wr(2'd0, 8'h01); rd(2'd1, r); check("R5 dir untouched", r, 8'hFF);
    wr(2'd0, 8'h02); rd(2'd1, r); check("R5 alt-enable untouched", r, 8'h00);
    wr(2'd0, 8'h03); rd(2'd1, r); check("R5 open-drain untouched", r, 8'h00);
    check_pads("R5 pads untouched");

    // R9: output data reaches pad one clock after the write
    wr(2'd0, 8'h01); wr(2'd1, 8'h00);
    @(negedge clk);
    bus_sel = 2'd2; bus_wdata = 8'hC3; bus_wr = 1'b1;
    #1ns; check("R9 pad before edge", pad_out, 8'h00);
    @(negedge clk); bus_wr = 1'b0; m_data = 8'hC3;
    check_pads("R9 pad after edge");
    rd(2'd2, r); check("R9 data readback", r, 8'hC3);

    // R8 directed: open-drain on alt pins and normal pins
    wr(2'd0, 8'h03); wr(2'd1, 8'hFF);
    wr(2'd0, 8'h02); wr(2'd1, 8'hF0);
    @(negedge clk); alt_out = 8'hA0; alt_oe = 8'hFF;
    check_pads("R8 open-drain mixed");
    rd(2'd3, r); check("R10 write ignored precheck", r, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, r); check("R10 input write ignored", r, 8'h00);

    // R10: two-edge latency in any mode
    prev = 8'h00;
    for (int k = 0; k < 20; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      @(negedge clk); pad_in = v;
      @(negedge clk); rd(2'd3, r); check("R10 one edge old", r, prev);
      @(negedge clk); rd(2'd3, r); check("R10 two edges new", r, v);
      prev = v;
    end

    // random configuration and alternate traffic
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: wr(2'd2, 8'($urandom));
        1: begin
             wr(2'd0, 8'($urandom_range(0, 5)));
             wr(2'd1, 8'($urandom));
           end
        2: begin
             @(negedge clk);
             alt_out = 8'($urandom); alt_oe = 8'($urandom);
           end
        default: begin
             logic [7:0] ix;
             ix = 8'($urandom_range(0, 5));
             wr(2'd0, ix);
             rd(2'd1, r); check("R2 R3 R4 R5 window readback", r, exp_win(ix));
           end
      endcase
      if (m_od != 8'h00)      check_pads("R8 random");
      else if (m_af != 8'h00) check_pads("R7 random");
      else                    check_pads("R6 random");
    end

    finish_up();
  end

endmodule